// File: doc/BRIEF.md
# Edge-Configurable Set/Clear Latch

This block keeps one output bit that is driven high by an edge on a set input and driven low by an edge on a clear input. Each input has its own edge selector: rising, falling, either edge, or no edge. Edges are found by comparing each input with its value on the previous clock. The output is a register, so it shows the new value on the same clock edge that first sees the changed input level.

Two write strobes drive the output high or low directly. They override any input edge. A clear request always wins over a set request of the same kind. An enable input controls whether input edges are used at all. While enable is low, a mode input decides the output: force it low, force it high, or hold its value. The edge selectors and the mode are plain ports. They stand in for register fields written by a host, and their current value is used in the same cycle it is presented.

Top module: `edge_sr_latch`

## Requirements
- R1: While `rst_ni` is low the output is 0, and the input history registers are 0.
- R2: With `set_edge_i` = 0 (rising), a 0-to-1 change on `set_in_i` drives `out_o` to 1 at the clock edge that samples the new level. With 1 (falling), only a 1-to-0 change acts.
- R3: `clr_edge_i` uses the same encoding as `set_edge_i`, and its selected edge on `clr_in_i` drives `out_o` to 0.
- R4: Edge-select value 2 (either) acts on both a 0-to-1 and a 1-to-0 change.
- R5: Edge-select value 3 is reserved and matches no edge, so that input never changes `out_o`.
- R6: When the set and clear inputs both show their selected edge in the same cycle, `out_o` becomes 0.
- R7: While `enable_i` is low, edges on both inputs are ignored. With `dis_mode_i` = 0 the output is driven to 0.
- R8: While disabled, `dis_mode_i` = 1 drives the output to 1, and `dis_mode_i` = 2 (and the reserved value 3) holds it.
- R9: `force_clr_i` drives `out_o` to 0 and `force_set_i` drives it to 1 on the next edge, overriding any input edge. `force_clr_i` wins when both strobes are high.
- R10: The force strobes act while disabled. On the following cycle the disable mode applies again, except that hold mode keeps the forced value.
- R11: The edge selector is compared in the same cycle it is presented. Switching to falling in the same cycle as a rising edge ignores that edge, and the next falling edge acts. Switching to falling in the same cycle as a falling edge lets that edge act.
- R12: The input history keeps tracking while disabled. Re-enabling with an input held at a level reached while disabled produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | High: input edges are used |
| set_in_i | input | 1 | Set source level |
| clr_in_i | input | 1 | Clear source level |
| force_set_i | input | 1 | One-cycle strobe that forces the output to 1 |
| force_clr_i | input | 1 | One-cycle strobe that forces the output to 0 |
| set_edge_i | input | 2 | Set edge select: 0 rise, 1 fall, 2 either, 3 none |
| clr_edge_i | input | 2 | Clear edge select: 0 rise, 1 fall, 2 either, 3 none |
| dis_mode_i | input | 2 | Disabled output: 0 low, 1 high, 2 or 3 hold |
| out_o | output | 1 | Latched output |

## Verification
The set and clear inputs are toggled under every edge selector. Each selector is tested on both directions of change, which shows whether it is decoded correctly and whether the reserved value is inert. Coincident patterns test the priorities: a set edge and a clear edge together, a force strobe together with an opposing edge, and both strobes together. Selector changes made in the same cycle as an input change show whether the live selector value is used. Level changes made while disabled, followed by re-enabling, show whether the history tracking stays continuous across the enable change.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    DIS_LOW   = 2'd0,
    DIS_HIGH  = 2'd1,
    DIS_HOLD  = 2'd2,
    DIS_RSVD  = 2'd3
  } dis_mode_e;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_SET = 0;
  localparam int unsigned SRC_CLR = 1;
endpackage

// File: rtl/srl_edge_det.sv
module srl_edge_det
  import srl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  // history tracks every cycle, independent of enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise = sig_i & ~prev_q;
  assign fall = ~sig_i & prev_q;

  // live selector: a same-cycle write applies to the edge being seen now
  always_comb begin
    case (edge_sel_e'(sel_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/srl_resolve.sv
module srl_resolve
  import srl_pkg::*;
(
  input  logic       cur_i,
  input  logic       enable_i,
  input  logic       set_hit_i,
  input  logic       clr_hit_i,
  input  logic       force_set_i,
  input  logic       force_clr_i,
  input  logic [1:0] dis_mode_i,
  output logic       nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (force_clr_i) begin
      nxt_o = 1'b0;
    end else if (force_set_i) begin
      nxt_o = 1'b1;
    end else if (!enable_i) begin
      case (dis_mode_e'(dis_mode_i))
        DIS_LOW:  nxt_o = 1'b0;
        DIS_HIGH: nxt_o = 1'b1;
        default:  nxt_o = cur_i;
      endcase
    end else if (clr_hit_i) begin
      nxt_o = 1'b0;
    end else if (set_hit_i) begin
      nxt_o = 1'b1;
    end
  end
endmodule

// File: rtl/edge_sr_latch.sv
module edge_sr_latch
  import srl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       set_in_i,
  input  logic       clr_in_i,
  input  logic       force_set_i,
  input  logic       force_clr_i,
  input  logic [1:0] set_edge_i,
  input  logic [1:0] clr_edge_i,
  input  logic [1:0] dis_mode_i,
  output logic       out_o
);
  logic [NUM_SRC-1:0]      src_sig;
  logic [NUM_SRC-1:0][1:0] src_sel;
  logic [NUM_SRC-1:0]      src_hit;
  logic                    out_q, out_d;

  assign src_sig[SRC_SET] = set_in_i;
  assign src_sig[SRC_CLR] = clr_in_i;
  assign src_sel[SRC_SET] = set_edge_i;
  assign src_sel[SRC_CLR] = clr_edge_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_det
    srl_edge_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (src_sig[g]),
      .sel_i  (src_sel[g]),
      .hit_o  (src_hit[g])
    );
  end

  srl_resolve u_res (
    .cur_i       (out_q),
    .enable_i    (enable_i),
    .set_hit_i   (src_hit[SRC_SET]),
    .clr_hit_i   (src_hit[SRC_CLR]),
    .force_set_i (force_set_i),
    .force_clr_i (force_clr_i),
    .dis_mode_i  (dis_mode_i),
    .nxt_o       (out_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/srl_chk.sv
module srl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       force_set_i,
  input logic       force_clr_i,
  input logic [1:0] set_edge_i,
  input logic [1:0] clr_edge_i,
  input logic [1:0] dis_mode_i,
  input logic       out_o
);
  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |=> (!rst_ni -> !out_o));

  // R9
  force_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_clr_i |=> !out_o);

  // R9
  force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_set_i && !force_clr_i) |=> out_o);

  // R7
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !force_set_i && !force_clr_i && dis_mode_i == 2'd0) |=> !out_o);

  // R8
  dis_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !force_set_i && !force_clr_i && dis_mode_i == 2'd1) |=> out_o);

  // R8
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !force_set_i && !force_clr_i && dis_mode_i[1]) |=> $stable(out_o));

  // R5
  no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !force_set_i && !force_clr_i && set_edge_i == 2'd3 && clr_edge_i == 2'd3)
      |=> $stable(out_o));
endmodule

bind edge_sr_latch srl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .force_set_i (force_set_i),
  .force_clr_i (force_clr_i),
  .set_edge_i  (set_edge_i),
  .clr_edge_i  (clr_edge_i),
  .dis_mode_i  (dis_mode_i),
  .out_o       (out_o)
);

// File: tb/sim_edge_sr_latch.sv
`timescale 1ns/1ps
module sim_edge_sr_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, s_in = 1'b0, c_in = 1'b0, f_set = 1'b0, f_clr = 1'b0;
  logic [1:0] s_edge = 2'd0, c_edge = 2'd0, d_mode = 2'd0;
  logic       out;
  int         n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  edge_sr_latch u0 (
    .clk_i (clk), .rst_ni (rst_n), .enable_i (en),
    .set_in_i (s_in), .clr_in_i (c_in),
    .force_set_i (f_set), .force_clr_i (f_clr),
    .set_edge_i (s_edge), .clr_edge_i (c_edge), .dis_mode_i (d_mode),
    .out_o (out)
  );

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (out !== exp) begin
      n_err++;
      $display("FAIL %s: out_o=%b expected %b at %0t", req, out, exp, $time);
    end
  endtask

  // inputs change after a falling edge; result checked at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; s_in = 1'b1;
    step(); chk("R1", 1'b0);
    s_in = 1'b0;
    step(); chk("R1", 1'b0);
    rst_n = 1'b1;
    step(); chk("R1", 1'b0);
  endtask

  task automatic t_rise();
    s_edge = 2'd0; c_edge = 2'd0;
    s_in = 1'b1; step(); chk("R2", 1'b1);
    c_in = 1'b1; step(); chk("R3", 1'b0);
    s_in = 1'b0; step(); chk("R2", 1'b0);
    c_in = 1'b0; step(); chk("R3", 1'b0);
  endtask

  task automatic t_fall();
    s_edge = 2'd1; c_edge = 2'd1;
    s_in = 1'b1; step(); chk("R2", 1'b0);
    s_in = 1'b0; step(); chk("R2", 1'b1);
    c_in = 1'b1; step(); chk("R3", 1'b1);
    c_in = 1'b0; step(); chk("R3", 1'b0);
  endtask

  task automatic t_either();
    s_edge = 2'd2; c_edge = 2'd2;
    s_in = 1'b1; step(); chk("R4", 1'b1);
    c_in = 1'b1; step(); chk("R4", 1'b0);
    s_in = 1'b0; step(); chk("R4", 1'b1);
    c_in = 1'b0; step(); chk("R4", 1'b0);
  endtask

  task automatic t_reserved();
    s_edge = 2'd3; c_edge = 2'd3;
    s_in = 1'b1; step(); chk("R5", 1'b0);
    s_in = 1'b0; step(); chk("R5", 1'b0);
    s_edge = 2'd0;
    s_in = 1'b1; step(); chk("R2", 1'b1);
    c_in = 1'b1; step(); chk("R5", 1'b1);
    c_in = 1'b0; step(); chk("R5", 1'b1);
    s_in = 1'b0; step();
    c_edge = 2'd0;
  endtask

  task automatic t_both();
    s_in = 1'b1; c_in = 1'b1; step(); chk("R6", 1'b0);
    s_in = 1'b0; c_in = 1'b0; step(); chk("R6", 1'b0);
  endtask

  task automatic t_force();
    f_set = 1'b1; step(); chk("R9", 1'b1);
    c_in = 1'b1; step(); chk("R9", 1'b1);
    f_set = 1'b0; c_in = 1'b0; step(); chk("R9", 1'b1);
    f_set = 1'b1; f_clr = 1'b1; step(); chk("R9", 1'b0);
    f_set = 1'b0; s_in = 1'b1; step(); chk("R9", 1'b0);
    f_clr = 1'b0; s_in = 1'b0; step(); chk("R9", 1'b0);
  endtask

  task automatic t_disable();
    s_in = 1'b1; step(); chk("R2", 1'b1);
    en = 1'b0; d_mode = 2'd0; step(); chk("R7", 1'b0);
    s_in = 1'b0; step();
    s_in = 1'b1; step(); chk("R7", 1'b0);
    d_mode = 2'd1; step(); chk("R8", 1'b1);
    c_in = 1'b1; step(); chk("R8", 1'b1);
    c_in = 1'b0; step(); chk("R8", 1'b1);
    d_mode = 2'd2; step(); chk("R8", 1'b1);
    f_clr = 1'b1; step(); chk("R10", 1'b0);
    f_clr = 1'b0; step(); chk("R10", 1'b0);
    f_set = 1'b1; step(); chk("R10", 1'b1);
    f_set = 1'b0; step(); chk("R10", 1'b1);
    d_mode = 2'd0; step(); chk("R7", 1'b0);
    f_set = 1'b1; step(); chk("R10", 1'b1);
    f_set = 1'b0; step(); chk("R10", 1'b0);
  endtask

  task automatic t_reenable();
    s_in = 1'b0; step(); chk("R12", 1'b0);
    s_in = 1'b1; step(); chk("R12", 1'b0);
    en = 1'b1; step(); chk("R12", 1'b0);
    s_in = 1'b0; step(); chk("R12", 1'b0);
  endtask

  task automatic t_sel_change();
    s_edge = 2'd1; s_in = 1'b1; step(); chk("R11", 1'b0);
    s_in = 1'b0; step(); chk("R11", 1'b1);
    s_edge = 2'd0; s_in = 1'b1; step(); chk("R11", 1'b1);
    f_clr = 1'b1; step(); chk("R9", 1'b0);
    f_clr = 1'b0; s_edge = 2'd1; s_in = 1'b0; step(); chk("R11", 1'b1);
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_either();
    t_reserved();
    t_both();
    t_force();
    t_disable();
    t_reenable();
    t_sel_change();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule